// File: doc/BRIEF.md
# Periodic Burst Trigger Generator

The block produces bursts of test trigger pulses. A host presents four settings: the spacing between triggers, how many triggers make up one burst, how wide each trigger pulse is, and whether a one-cycle timestamp-reset pulse goes out ahead of every trigger. A one-cycle start strobe launches a burst. The block captures the settings when it accepts the strobe, so the host can leave them in place and strobe again to repeat the same burst.

Time is counted in clock cycles of the 100 MHz clock, so one unit is 10 ns. Each trigger occupies a slot whose length is the spacing setting. A busy flag is high while a burst runs. A rate meter counts the trigger pulses started during each gate window. At the default of 100,000,000 cycles the window is one second, so the reported value is in Hz.

Top module: `burst_trig_gen`

## Requirements
- R1: While idle, a start strobe with a nonzero count makes `busy_o` high from the next cycle. It stays high for exactly count × slot-length cycles and is then low.
- R2: Each slot lasts `period_i` cycles, and a period of 0 acts as 1. Slot k of a burst begins k × slot-length cycles after the first busy cycle.
- R3: With a nonzero width W, `trig_o` is high in slot offsets o..o+W-1 and is cut off at the end of the slot. The offset o is 1 when the timestamp-reset option is on and 0 when it is off.
- R4: A width of 0 keeps `trig_o` low for the whole burst while busy and slot timing stay unchanged.
- R5: With `tsrst_en_i` = 1, `tsrst_o` is high for one cycle at offset 0 of every slot, and never in the same cycle as `trig_o`.
- R6: The settings are captured when a start is accepted. Changing the inputs during a burst has no effect on that burst.
- R7: A start strobe that arrives while busy is ignored, and the running burst continues unchanged.
- R8: A start strobe with a count of 0 starts nothing, and the outputs stay low.
- R9: `rate_o` shows how many trigger pulses were started in the last gate window of GATE_CYCLES cycles. The window count starts at reset release, and `rate_o` is updated only at the end of each window. A slot with width 0 starts no pulse.
- R10: While reset is high, and in the cycle after it, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle start strobe |
| period_i | input | 16 | Slot length in cycles (0 acts as 1) |
| count_i | input | 8 | Triggers per burst |
| width_i | input | 16 | Trigger pulse width in cycles (0 means no pulse) |
| tsrst_en_i | input | 1 | Emit a timestamp-reset pulse before each trigger |
| trig_o | output | 1 | Trigger pulse |
| tsrst_o | output | 1 | Timestamp-reset pulse |
| busy_o | output | 1 | Burst in progress |
| rate_o | output | RATE_W | Pulses started in the last gate window |

## Verification
The bench sweeps slot lengths 0, 1, 2, 3 and 5, counts 1 to 3, and widths 0, 1, 2, 4 and 6, each with the timestamp-reset option on and off. It compares every output in every cycle against a formula for the slot offset. This separates the clipping of pulses wider than the slot, the one-cycle shift caused by the timestamp-reset option, and the treatment of a zero period. During each burst the settings inputs are scrambled, and in the longer bursts a second strobe is sent. A latch or restart error then shows up as a waveform mismatch. Three gate windows with 5, 0 and 7 expected pulses test the counting, the latching and the clearing of the rate meter.

// File: rtl/burst_trig_pkg.sv
package burst_trig_pkg;
  localparam int PER_W = 16;
  localparam int CNT_W = 8;
  localparam int LEN_W = 16;

  typedef struct packed {
    logic [PER_W-1:0] period;
    logic [CNT_W-1:0] count;
    logic [LEN_W-1:0] len;
    logic             tsrst_en;
  } burst_cfg_t;
endpackage

// File: rtl/btg_slot_seq.sv
// Burst sequencer: snapshots the settings on an accepted start and walks
// slot offsets. The next-state values are exported so that downstream
// outputs can be registered with no extra cycle of latency.
module btg_slot_seq
  import burst_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  burst_cfg_t       cfg_i,
  output logic             run_o,
  output logic             nxt_run_o,
  output logic [PER_W-1:0] nxt_pos_o,
  output logic [LEN_W-1:0] nxt_len_o,
  output logic             nxt_en_o
);
  logic             run_q, nxt_run;
  logic [PER_W-1:0] pos_q, nxt_pos, last_pos;
  logic [CNT_W-1:0] left_q, nxt_left;
  burst_cfg_t       cfg_q, nxt_cfg;

  assign last_pos = (cfg_q.period == '0) ? '0 : cfg_q.period - PER_W'(1);

  always_comb begin
    nxt_run  = run_q;
    nxt_pos  = pos_q;
    nxt_left = left_q;
    nxt_cfg  = cfg_q;
    if (!run_q) begin
      if (start_i && cfg_i.count != '0) begin
        nxt_run  = 1'b1;
        nxt_pos  = '0;
        nxt_left = cfg_i.count;
        nxt_cfg  = cfg_i;
      end
    end else if (pos_q == last_pos) begin
      if (left_q == CNT_W'(1)) begin
        nxt_run = 1'b0;
      end else begin
        nxt_left = left_q - CNT_W'(1);
        nxt_pos  = '0;
      end
    end else begin
      nxt_pos = pos_q + PER_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pos_q  <= '0;
      left_q <= '0;
      cfg_q  <= '0;
    end else begin
      run_q  <= nxt_run;
      pos_q  <= nxt_pos;
      left_q <= nxt_left;
      cfg_q  <= nxt_cfg;
    end
  end

  assign run_o     = run_q;
  assign nxt_run_o = nxt_run;
  assign nxt_pos_o = nxt_pos;
  assign nxt_len_o = nxt_cfg.len;
  assign nxt_en_o  = nxt_cfg.tsrst_en;
endmodule

// File: rtl/btg_pulse_shape.sv
// Derives the trigger and timestamp-reset levels from the next slot offset
// and registers them. It also flags the cycle in which a pulse starts.
module btg_pulse_shape
  import burst_trig_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             nxt_run_i,
  input  logic [PER_W-1:0] nxt_pos_i,
  input  logic [LEN_W-1:0] nxt_len_i,
  input  logic             nxt_en_i,
  output logic             trig_o,
  output logic             tsrst_o,
  output logic             pulse_evt_o
);
  localparam int CW = ((PER_W > LEN_W) ? PER_W : LEN_W) + 1;

  logic [CW-1:0] pos_w, off_w, end_w;
  logic          trig_d, tsrst_d;

  assign pos_w = CW'(nxt_pos_i);
  assign off_w = CW'(nxt_en_i);
  assign end_w = off_w + CW'(nxt_len_i);

  assign trig_d      = nxt_run_i && (nxt_len_i != '0) && (pos_w >= off_w) && (pos_w < end_w);
  assign tsrst_d     = nxt_run_i && nxt_en_i && (nxt_pos_i == '0);
  assign pulse_evt_o = nxt_run_i && (nxt_len_i != '0) && (pos_w == off_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_o  <= 1'b0;
      tsrst_o <= 1'b0;
    end else begin
      trig_o  <= trig_d;
      tsrst_o <= tsrst_d;
    end
  end
endmodule

// File: rtl/btg_rate_meter.sv
// Counts pulse starts over a fixed gate window and latches the total.
module btg_rate_meter #(
  parameter int GATE_CYCLES = 100_000_000,
  parameter int RATE_W      = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt_i,
  output logic [RATE_W-1:0] rate_o
);
  localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [GW-1:0] GATE_LAST = GW'(GATE_CYCLES - 1);

  logic [GW-1:0]     gate_q;
  logic [RATE_W-1:0] acc_q, acc_inc;

  assign acc_inc = acc_q + RATE_W'(evt_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q <= '0;
      acc_q  <= '0;
      rate_o <= '0;
    end else if (gate_q == GATE_LAST) begin
      gate_q <= '0;
      acc_q  <= '0;
      rate_o <= acc_inc;
    end else begin
      gate_q <= gate_q + GW'(1);
      acc_q  <= acc_inc;
    end
  end
endmodule

// File: rtl/burst_trig_gen.sv
module burst_trig_gen
  import burst_trig_pkg::*;
#(
  parameter int GATE_CYCLES = 100_000_000,
  parameter int RATE_W      = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [PER_W-1:0]  period_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [LEN_W-1:0]  width_i,
  input  logic              tsrst_en_i,
  output logic              trig_o,
  output logic              tsrst_o,
  output logic              busy_o,
  output logic [RATE_W-1:0] rate_o
);
  burst_cfg_t       cfg_in;
  logic             nxt_run, nxt_en, pulse_evt;
  logic [PER_W-1:0] nxt_pos;
  logic [LEN_W-1:0] nxt_len;

  assign cfg_in = '{period: period_i, count: count_i, len: width_i, tsrst_en: tsrst_en_i};

  btg_slot_seq seq_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .cfg_i     (cfg_in),
    .run_o     (busy_o),
    .nxt_run_o (nxt_run),
    .nxt_pos_o (nxt_pos),
    .nxt_len_o (nxt_len),
    .nxt_en_o  (nxt_en)
  );

  btg_pulse_shape shape_i (
    .clk         (clk),
    .rst         (rst),
    .nxt_run_i   (nxt_run),
    .nxt_pos_i   (nxt_pos),
    .nxt_len_i   (nxt_len),
    .nxt_en_i    (nxt_en),
    .trig_o      (trig_o),
    .tsrst_o     (tsrst_o),
    .pulse_evt_o (pulse_evt)
  );

  btg_rate_meter #(.GATE_CYCLES(GATE_CYCLES), .RATE_W(RATE_W)) rate_i (
    .clk    (clk),
    .rst    (rst),
    .evt_i  (pulse_evt),
    .rate_o (rate_o)
  );
endmodule

// File: rtl/btg_checker.sv
module btg_checker #(
  parameter int GATE_CYCLES = 100_000_000,
  parameter int RATE_W      = 28
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              trig_o,
  input logic              tsrst_o,
  input logic              busy_o,
  input logic [RATE_W-1:0] rate_o
);
  localparam int GW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;

  // Independent down-counter that tracks the gate window boundary.
  logic [GW-1:0] left_q;
  always_ff @(posedge clk) begin
    if (rst)                 left_q <= GW'(GATE_CYCLES - 1);
    else if (left_q == '0)   left_q <= GW'(GATE_CYCLES - 1);
    else                     left_q <= left_q - GW'(1);
  end

  p_busy_after_start_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(start_i));

  p_trig_in_burst_r3: assert property (@(posedge clk) disable iff (rst)
    trig_o |-> busy_o);

  p_tsrst_in_burst_r5: assert property (@(posedge clk) disable iff (rst)
    tsrst_o |-> busy_o);

  p_tsrst_apart_r5: assert property (@(posedge clk) disable iff (rst)
    tsrst_o |-> !trig_o);

  p_rate_at_gate_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(rate_o) |-> (left_q == GW'(GATE_CYCLES - 1)));

  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> (!busy_o && !trig_o && !tsrst_o && rate_o == '0));
endmodule

bind burst_trig_gen btg_checker #(.GATE_CYCLES(GATE_CYCLES), .RATE_W(RATE_W)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .trig_o  (trig_o),
  .tsrst_o (tsrst_o),
  .busy_o  (busy_o),
  .rate_o  (rate_o)
);

// File: tb/burst_trig_gen_tb_top.sv
module burst_trig_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GATE = 500;
  localparam int RW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic [15:0]   period_i = '0;
  logic [7:0]    count_i = '0;
  logic [15:0]   width_i = '0;
  logic          tsrst_en_i = 1'b0;
  logic          trig_o, tsrst_o, busy_o;
  logic [RW-1:0] rate_o;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  burst_trig_gen #(.GATE_CYCLES(GATE), .RATE_W(RW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .period_i(period_i),
    .count_i(count_i), .width_i(width_i), .tsrst_en_i(tsrst_en_i),
    .trig_o(trig_o), .tsrst_o(tsrst_o), .busy_o(busy_o), .rate_o(rate_o)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at t=%0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  // One burst with cycle-exact comparison of all outputs.
  task automatic run_burst(int p, int n, int l, int en);
    int pe, total;
    bit inject;
    pe = (p == 0) ? 1 : p;
    total = n * pe;
    inject = (total >= 3);
    @(negedge clk);
    period_i = 16'(p); count_i = 8'(n); width_i = 16'(l); tsrst_en_i = en[0];
    start_i = 1'b1;
    check("R1 idle before start", int'(busy_o), 0);
    @(negedge clk);
    start_i = 1'b0;
    // R6: scramble the inputs once the settings have been captured
    period_i = 16'(p + 3); count_i = 8'(n + 2); width_i = 16'(l + 5); tsrst_en_i = ~en[0];
    for (int t = 1; t <= total + 2; t++) begin
      int j, eb, et, es;
      j  = (t - 1) % pe;
      eb = (t <= total) ? 1 : 0;
      es = (eb == 1 && en == 1 && j == 0) ? 1 : 0;
      et = (eb == 1 && l != 0 && j >= en && j < en + l) ? 1 : 0;
      check("R1 R2 R7 busy", int'(busy_o), eb);
      check((l == 0) ? "R4 R6 trig" : "R3 R6 trig", int'(trig_o), et);
      check("R5 R6 tsrst", int'(tsrst_o), es);
      if (inject && t == 2) start_i = 1'b1;   // R7: strobe during a burst
      else start_i = 1'b0;
      @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  task automatic launch(int p, int n, int l, int en);
    @(negedge clk);
    period_i = 16'(p); count_i = 8'(n); width_i = 16'(l); tsrst_en_i = en[0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_cyc(int k);
    while (cyc < k) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : stim
    int per_set[5] = '{0, 1, 2, 3, 5};
    int len_set[5] = '{0, 1, 2, 4, 6};
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: outputs while reset is held
    check("R10 busy in reset", int'(busy_o), 0);
    check("R10 trig in reset", int'(trig_o), 0);
    check("R10 tsrst in reset", int'(tsrst_o), 0);
    check("R10 rate in reset", int'(rate_o), 0);
    rst = 1'b0;

    // R8: count of zero starts nothing
    @(negedge clk);
    period_i = 16'd3; count_i = 8'd0; width_i = 16'd2; tsrst_en_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int t = 0; t < 4; t++) begin
      check("R8 busy", int'(busy_o), 0);
      check("R8 trig", int'(trig_o), 0);
      check("R8 tsrst", int'(tsrst_o), 0);
      @(negedge clk);
    end

    // R1..R7 sweep
    foreach (per_set[pi])
      for (int n = 1; n <= 3; n++)
        foreach (len_set[li])
          for (int en = 0; en < 2; en++)
            run_burst(per_set[pi], n, len_set[li], en);

    // R9: rate windows from a fresh reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    launch(4, 5, 2, 1);
    wait_cyc(GATE - 10);
    check("R9 rate before first gate", int'(rate_o), 0);
    wait_cyc(GATE + 20);
    check("R9 rate window 1", int'(rate_o), 5);
    launch(4, 3, 0, 0);
    wait_cyc(2 * GATE + 20);
    check("R9 rate window 2 zero width", int'(rate_o), 0);
    launch(1, 7, 1, 0);
    wait_cyc(3 * GATE + 20);
    check("R9 rate window 3", int'(rate_o), 7);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule